// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an 8-bit parallel NOR-style flash bus and turns simple operation requests into the bus traffic the flash expects. A request asks for one of three things: write one byte, clear a chosen set of sectors, or clear the whole array. The block first writes a fixed series of unlock and command bytes to magic addresses. It then repeatedly reads the array and watches the top data bit until the internal operation reports completion. If completion never shows up within a set number of reads, it gives up.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on any clock edge where both `req_valid` and `req_ready` are high, and its fields are copied at that edge. Back-pressure is simply `req_ready` staying low for the whole of an operation. A requester holds `req_valid` and its fields until it sees ready. When an operation ends, the block raises `done` or `error` for exactly one cycle.

Every bus phase length is a cycle count. Each count is derived at elaboration from nanosecond parameters and the clock period, rounding up.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `busy`, `done` and `error` are low. `req_ready` is high.
- R2: A byte write request (`req_op` = 2'b00) produces exactly four bus writes in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request byte at the request address.
- R3: A sector clear request (`req_op` = 2'b01) produces AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. After these comes one 30h write per set bit of `req_sectors`, lowest bit first. Each of those writes goes to the sector base address, which is the bit index placed in the top log2(NSECT) address bits (bit index << 16 with the defaults).
- R4: A whole-array clear request (`req_op` = 2'b10) produces the same five opening writes as R3, then one 10h write at 5555h.
- R5: During each write, `fl_oe_n` is high and `fl_ce_n` is low, and the data is driven. `fl_we_n` is low for exactly ceil(max(T_WP_NS, T_DS_NS)/CLK_NS) cycles (4 with the defaults). Address and data stay unchanged across the rising edge of `fl_we_n`. `fl_oe_n` is never low while `fl_we_n` is low.
- R6: After the last write, the block runs read cycles. In each one `fl_oe_n` is held low for ceil(T_ACC_NS/CLK_NS) cycles. The read address is the target address for a byte write, the highest selected sector base for a sector clear, and 0 for a whole-array clear. A read completes the operation when `fl_dq7` equals bit 7 of the written byte (byte write) or equals 1 (clears). Completion gives a one-cycle `done` pulse, and `busy` falls in that same cycle.
- R7: If PROG_POLLS reads (byte write) or ERASE_POLLS reads (clears) all fail to match, the block stops after the last of them, pulses `error` for one cycle and returns to idle.
- R8: `req_ready` is low and `busy` is high from the cycle after acceptance until the cycle in which `done` or `error` is raised.
- R9: A request with `req_op` = 2'b11, or a sector clear with `req_sectors` all zero, is accepted. It produces an `error` pulse in the next cycle with no bus write and no read.
- R10: Changes to the request fields after acceptance do not affect the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 00 byte write, 01 sector clear, 10 whole-array clear, 11 invalid |
| req_addr | input | AW | Byte write target address |
| req_data | input | 8 | Byte to write |
| req_sectors | input | NSECT | Sector selection mask, bit i selects sector i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| error | output | 1 | One-cycle pulse: timeout or invalid request |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_dout_en | output | 1 | Write data drive enable |
| fl_dq7 | input | 1 | Flash data bit 7 as read back |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Byte writes are tried with data whose top bit is 0 and data whose top bit is 1. This tells apart a sequencer that compares against the written bit from one that compares against a constant. Every one of the 255 non-empty sector masks is swept, which exposes ordering, skipped or repeated sectors, and a wrong final read address. Across these runs the read that reports completion moves from the first read to beyond the limit, which separates an early exit, an off-by-one in the timeout count and a missed error. Invalid operation codes and an empty mask check the reject path, and changing the request fields after acceptance checks that they were captured.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSU,
    S_WLO,
    S_WHI,
    S_RACC,
    S_RGAP
  } st_e;

  localparam logic [15:0] KEY_A   = 16'h5555;
  localparam logic [15:0] KEY_B   = 16'h2AAA;
  localparam logic [7:0]  KEY_A_D = 8'hAA;
  localparam logic [7:0]  KEY_B_D = 8'h55;
  localparam logic [7:0]  CMD_PRG = 8'hA0;
  localparam logic [7:0]  CMD_ERS = 8'h80;
  localparam logic [7:0]  CMD_SEC = 8'h30;
  localparam logic [7:0]  CMD_ALL = 8'h10;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic int lowest_bit(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  // address of unlock/command step 0..4
  function automatic logic [15:0] key_addr(input logic [2:0] s);
    return (s == 3'd1 || s == 3'd4) ? KEY_B : KEY_A;
  endfunction

  // data of unlock/command step 0..4
  function automatic logic [7:0] key_data(input logic [2:0] s, input logic is_prog);
    case (s)
      3'd1, 3'd4: return KEY_B_D;
      3'd2:       return is_prog ? CMD_PRG : CMD_ERS;
      default:    return KEY_A_D;
    endcase
  endfunction

endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - TW'(1);
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/flash_poll_counter.sv
module flash_poll_counter #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [PW-1:0] limit,
  output logic          last
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + PW'(1);
  end

  assign last = (cnt == limit - PW'(1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW          = 19,
  parameter int NSECT       = 8,
  parameter int CLK_NS      = 10,
  parameter int T_AS_NS     = 0,
  parameter int T_WP_NS     = 40,
  parameter int T_DS_NS     = 40,
  parameter int T_WPH_NS    = 20,
  parameter int T_AH_NS     = 45,
  parameter int T_ACC_NS    = 60,
  parameter int T_DF_NS     = 20,
  parameter int PROG_POLLS  = 4096,
  parameter int ERASE_POLLS = 1048576
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_data,
  input  logic [NSECT-1:0] req_sectors,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [AW-1:0]    fl_addr,
  output logic [7:0]       fl_dout,
  output logic             fl_dout_en,
  input  logic             fl_dq7,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n
);
  localparam int SW         = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int SECT_SHIFT = AW - SW;
  localparam int SU_CYC  = imax(cyc_ceil(T_AS_NS, CLK_NS), 1);
  localparam int WP_CYC  = imax(imax(cyc_ceil(T_WP_NS, CLK_NS), cyc_ceil(T_DS_NS, CLK_NS)), 1);
  localparam int WPH_CYC = imax(imax(cyc_ceil(T_WPH_NS, CLK_NS), cyc_ceil(T_AH_NS, CLK_NS) - WP_CYC), 1);
  localparam int RD_CYC  = imax(cyc_ceil(T_ACC_NS, CLK_NS), 1);
  localparam int GAP_CYC = imax(cyc_ceil(T_DF_NS, CLK_NS), 1);
  localparam int TMAX    = imax(imax(imax(SU_CYC, WP_CYC), imax(WPH_CYC, RD_CYC)), GAP_CYC);
  localparam int TW      = $clog2(TMAX + 1);
  localparam int PW      = $clog2(imax(PROG_POLLS, ERASE_POLLS) + 1);

  st_e              st;
  op_e              op_q;
  logic [AW-1:0]    tgt_q;
  logic [7:0]       dat_q;
  logic [NSECT-1:0] left_q;
  logic [SW-1:0]    last_sect_q;
  logic [2:0]       step_q;
  logic [AW-1:0]    a_q;
  logic [7:0]       d_q;
  logic             done_q, err_q;

  logic             tm_load, tm_exp;
  logic [TW-1:0]    tm_len;
  logic             pc_clr, pc_inc, pc_last;
  logic [PW-1:0]    pc_limit;

  logic             req_bad, accept, match;
  logic             nxt_poll;
  logic [2:0]       nxt_step;
  logic [AW-1:0]    nxt_a, poll_a;
  logic [7:0]       nxt_d;
  logic [NSECT-1:0] nxt_left;
  logic [SW-1:0]    nxt_sect, pick;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_bad   = (req_op == OP_BAD) || (req_op == OP_SECT && req_sectors == '0);
  assign match     = fl_dq7 == ((op_q == OP_PROG) ? dat_q[7] : 1'b1);
  assign pick      = SW'(lowest_bit(32'(left_q)));
  assign pc_limit  = (op_q == OP_PROG) ? PW'(PROG_POLLS) : PW'(ERASE_POLLS);

  always_comb begin
    case (op_q)
      OP_PROG: poll_a = tgt_q;
      OP_SECT: poll_a = AW'(last_sect_q) << SECT_SHIFT;
      default: poll_a = '0;
    endcase
  end

  // what follows the write that is finishing now
  always_comb begin
    nxt_step = step_q + 3'd1;
    nxt_left = left_q;
    nxt_sect = last_sect_q;
    nxt_a    = AW'(key_addr(nxt_step));
    nxt_d    = key_data(nxt_step, op_q == OP_PROG);
    nxt_poll = 1'b0;
    if (op_q == OP_PROG && step_q == 3'd3) begin
      nxt_poll = 1'b1;
    end else if (op_q == OP_PROG && step_q == 3'd2) begin
      nxt_a = tgt_q;
      nxt_d = dat_q;
    end else if (step_q >= 3'd4) begin
      nxt_step = 3'd5;
      if (op_q == OP_CHIP) begin
        nxt_poll = (step_q == 3'd5);
        nxt_a    = AW'(KEY_A);
        nxt_d    = CMD_ALL;
      end else begin
        nxt_poll = (left_q == '0);
        nxt_a    = AW'(pick) << SECT_SHIFT;
        nxt_d    = CMD_SEC;
        nxt_left = left_q & ~(NSECT'(1) << pick);
        nxt_sect = pick;
      end
    end
  end

  always_comb begin
    tm_load = 1'b0;
    tm_len  = TW'(SU_CYC);
    pc_clr  = 1'b0;
    pc_inc  = 1'b0;
    case (st)
      S_IDLE: tm_load = accept && !req_bad;
      S_WSU:  begin tm_load = tm_exp; tm_len = TW'(WP_CYC); end
      S_WLO:  begin tm_load = tm_exp; tm_len = TW'(WPH_CYC); end
      S_WHI:  begin
        tm_load = tm_exp;
        tm_len  = nxt_poll ? TW'(RD_CYC) : TW'(SU_CYC);
        pc_clr  = tm_exp && nxt_poll;
      end
      S_RACC: begin
        pc_inc  = tm_exp;
        tm_load = tm_exp && !match && !pc_last;
        tm_len  = TW'(GAP_CYC);
      end
      S_RGAP: begin tm_load = tm_exp; tm_len = TW'(RD_CYC); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= OP_PROG;
      tgt_q       <= '0;
      dat_q       <= '0;
      left_q      <= '0;
      last_sect_q <= '0;
      step_q      <= '0;
      a_q         <= '0;
      d_q         <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (req_bad) begin
            err_q <= 1'b1;
          end else begin
            op_q   <= op_e'(req_op);
            tgt_q  <= req_addr;
            dat_q  <= req_data;
            left_q <= req_sectors;
            step_q <= 3'd0;
            a_q    <= AW'(key_addr(3'd0));
            d_q    <= key_data(3'd0, req_op == OP_PROG);
            st     <= S_WSU;
          end
        end
        S_WSU: if (tm_exp) st <= S_WLO;
        S_WLO: if (tm_exp) st <= S_WHI;
        S_WHI: if (tm_exp) begin
          if (nxt_poll) begin
            a_q <= poll_a;
            st  <= S_RACC;
          end else begin
            step_q      <= nxt_step;
            left_q      <= nxt_left;
            last_sect_q <= nxt_sect;
            a_q         <= nxt_a;
            d_q         <= nxt_d;
            st          <= S_WSU;
          end
        end
        S_RACC: if (tm_exp) begin
          if (match) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (pc_last) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            st <= S_RGAP;
          end
        end
        S_RGAP: if (tm_exp) st <= S_RACC;
        default: st <= S_IDLE;
      endcase
    end
  end

  flash_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .len(tm_len), .expired(tm_exp)
  );

  flash_poll_counter #(.PW(PW)) u_polls (
    .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .limit(pc_limit), .last(pc_last)
  );

  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign error      = err_q;
  assign fl_addr    = a_q;
  assign fl_dout    = d_q;
  assign fl_dout_en = (st == S_WSU) || (st == S_WLO) || (st == S_WHI);
  assign fl_we_n    = (st != S_WLO);
  assign fl_oe_n    = (st != S_RACC);
  assign fl_ce_n    = (st == S_IDLE);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW     = 19,
  parameter int WP_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dout,
  input logic          fl_dout_en,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        lo_cnt <= '0;
    else if (!fl_we_n) lo_cnt <= lo_cnt + 16'd1;
    else               lo_cnt <= '0;
  end

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lo_cnt == 16'(WP_CYC)));

  // R5
  we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

  // R5
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_dout_en && !fl_ce_n));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .WP_CYC(WP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_LIM = 5;
  localparam int E_LIM = 7;
  localparam int WP    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [7:0]  req_sectors = '0;
  logic        busy, done, error;
  logic [18:0] fl_addr;
  logic [7:0]  fl_dout;
  logic        fl_dout_en, fl_dq7, fl_ce_n, fl_we_n, fl_oe_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // flash bus model state
  int          log_n = 0, log_base = 0, poll_n = 0, poll_base = 0;
  int          ready_after = 0;
  logic        exp_dq7 = 1'b0;
  logic [18:0] log_a [16];
  logic [7:0]  log_d [16];
  logic [18:0] last_poll_a = '0;
  logic [18:0] lo_a = '0;
  logic [7:0]  lo_d = '0;
  int          lo_run = 0, cur_poll = 0;
  int          ov_err = 0, wid_err = 0, stab_err = 0, rdy_err = 0;
  logic        prev_we = 1'b1, prev_oe = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.PROG_POLLS(P_LIM), .ERASE_POLLS(E_LIM)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_sectors(req_sectors),
    .busy(busy), .done(done), .error(error), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_dout_en(fl_dout_en), .fl_dq7(fl_dq7), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n)
  );

  assign fl_dq7 = (cur_poll >= ready_after) ? exp_dq7 : ~exp_dq7;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n && !fl_oe_n) ov_err++;
      if (req_ready && busy) rdy_err++;
      if (!fl_we_n) begin
        if (prev_we) begin lo_a = fl_addr; lo_d = fl_dout; end
        if (!fl_dout_en || fl_ce_n) ov_err++;
        lo_run++;
      end else if (!prev_we) begin
        if (lo_run != WP) wid_err++;
        if (fl_addr != lo_a || fl_dout != lo_d) stab_err++;
        if (log_n - log_base < 16) begin
          log_a[log_n - log_base] = fl_addr;
          log_d[log_n - log_base] = fl_dout;
        end
        log_n++;
        lo_run = 0;
      end
      if (prev_oe && !fl_oe_n) begin
        cur_poll = poll_n - poll_base;
        poll_n++;
        last_poll_a = fl_addr;
      end
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [18:0] addr, input logic [7:0] dat,
                        input logic [7:0] mask, input int ra);
    logic [18:0] ea [16];
    logic [7:0]  ed [16];
    int ne, lim, wait_n, mism, e_ov, e_wid, e_stab, e_rdy, exp_polls;
    logic [18:0] exp_pa;
    bit ok_op, exp_done;
    string tag;
    ok_op = !(op == 2'b11 || (op == 2'b01 && mask == 8'h00));
    ne = 0;
    exp_pa = '0;
    if (op == 2'b00) begin
      ea[0] = 19'h05555; ed[0] = 8'hAA; ea[1] = 19'h02AAA; ed[1] = 8'h55;
      ea[2] = 19'h05555; ed[2] = 8'hA0; ea[3] = addr;      ed[3] = dat;
      ne = 4; exp_pa = addr; tag = "R2";
    end else if (ok_op) begin
      ea[0] = 19'h05555; ed[0] = 8'hAA; ea[1] = 19'h02AAA; ed[1] = 8'h55;
      ea[2] = 19'h05555; ed[2] = 8'h80; ea[3] = 19'h05555; ed[3] = 8'hAA;
      ea[4] = 19'h02AAA; ed[4] = 8'h55; ne = 5;
      if (op == 2'b10) begin
        ea[5] = 19'h05555; ed[5] = 8'h10; ne = 6; tag = "R4";
      end else begin
        for (int i = 0; i < 8; i++) if (mask[i]) begin
          ea[ne] = 19'(i) << 16; ed[ne] = 8'h30; exp_pa = 19'(i) << 16; ne++;
        end
        tag = "R3";
      end
    end else tag = "R9";
    lim = (op == 2'b00) ? P_LIM : E_LIM;
    exp_done  = ra < lim;
    exp_polls = !ok_op ? 0 : (exp_done ? ra + 1 : lim);
    exp_dq7 = (op == 2'b00) ? dat[7] : 1'b1;
    ready_after = ra;
    log_base = log_n; poll_base = poll_n; cur_poll = 0;
    e_ov = ov_err; e_wid = wid_err; e_stab = stab_err; e_rdy = rdy_err;

    req_op = op; req_addr = addr; req_data = dat; req_sectors = mask; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble fields after acceptance
    req_op = ~op; req_addr = ~addr; req_data = ~dat; req_sectors = ~mask;
    if (ok_op) check(busy && !req_ready, "R8", "busy/ready after accept", {busy, req_ready}, 2'b10);
    else       check(error && !busy, "R9", "reject pulse", {error, busy}, 2'b10);
    wait_n = 0;
    while (!done && !error && wait_n < 30000) begin
      @(negedge clk);
      wait_n++;
    end
    if (ok_op)
      check(done == exp_done && error == !exp_done, exp_done ? "R6" : "R7", "outcome",
            {done, error}, {exp_done, !exp_done});
    check(!busy, "R8", "busy low at end", busy, 0);
    check(poll_n - poll_base == exp_polls, exp_done ? "R6" : "R7", "read count",
          poll_n - poll_base, exp_polls);
    check(log_n - log_base == ne, tag, "write count", log_n - log_base, ne);
    mism = 0;
    for (int i = 0; i < ne && i < 16; i++)
      if (log_a[i] != ea[i] || log_d[i] != ed[i]) mism++;
    check(mism == 0, tag, "write content (R10 fields captured)", mism, 0);
    if (ok_op) check(last_poll_a == exp_pa, "R6", "read address", last_poll_a, exp_pa);
    check(ov_err == e_ov && wid_err == e_wid && stab_err == e_stab, "R5", "write timing",
          (ov_err - e_ov) + (wid_err - e_wid) + (stab_err - e_stab), 0);
    check(rdy_err == e_rdy, "R8", "ready while busy", rdy_err - e_rdy, 0);
    @(negedge clk);
    check(!done && !error && req_ready, "R6", "single-cycle pulse, idle again",
          {done, error, req_ready}, 3'b001);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < 190000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'h7F; pats[2] = 8'h80;
    pats[3] = 8'hFF; pats[4] = 8'h5A; pats[5] = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fl_ce_n && fl_we_n && fl_oe_n && !busy && !done && !error && req_ready, "R1",
          "reset outputs", {fl_ce_n, fl_we_n, fl_oe_n, busy, done, error, req_ready}, 7'b1110001);
    rst_n = 1'b1;
    @(negedge clk);
    check(fl_ce_n && !busy && req_ready, "R1", "idle after reset", {fl_ce_n, busy, req_ready}, 3'b101);

    for (int p = 0; p < 6; p++)
      for (int r = 0; r <= P_LIM + 1; r++)
        run_op(2'b00, 19'h7FFFF ^ 19'(p * 19'h1357 + r), pats[p], 8'h00, r);

    for (int m = 1; m < 256; m++)
      run_op(2'b01, 19'h00000, 8'h00, 8'(m), m % (E_LIM + 2));

    for (int r = 0; r <= E_LIM + 1; r++)
      run_op(2'b10, 19'h12345, 8'h00, 8'h00, r);

    run_op(2'b11, 19'h00001, 8'h11, 8'hFF, 0);
    run_op(2'b01, 19'h00002, 8'h22, 8'h00, 0);
    run_op(2'b00, 19'h0ABCD, 8'hC3, 8'h00, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule